// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt requests for a simple CPU core that runs one instruction per cycle. It watches a parameterised set of request lines (sixteen by default) and catches each rising edge in a pending bit. Pending requests are offered to the core only when the core signals the end of an instruction. A higher-priority request may interrupt a handler that is already running, and the block keeps track of which channels are being serviced so that this nesting stays in order. After the core accepts a request, it fetches the vector-table word for that channel and hands it back. The block then decodes the word for dispatch.

The state machine has four states. IDLE holds while nothing is eligible. On an instruction boundary with interrupts enabled and an eligible winner, IDLE goes to OFFER. OFFER holds the request and channel number steady until the core acknowledges, then goes to FETCH. FETCH waits for the vector word and goes to DISPATCH when it arrives. DISPATCH presents the decoded entry for exactly one cycle and returns to IDLE.

In a vector word, bit 0 selects the dispatch mode. With bit 0 clear, the whole word goes out as a segment descriptor. With bit 0 set, the word is a direct handler address. Handlers are aligned to 8 words, so the address is taken with its three low bits cleared, and bits 2:1 carry a two-bit protection field.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `int_req` and `dispatch_valid` are low, no channel is in service and no request is pending.
- R2: A low-to-high transition on a request line sets that channel's pending bit. A line held high produces no second request after the first one is acknowledged.
- R3: A request is offered (`int_req` rises) only in the cycle after one in which `cycle_end` and `int_enable` were both high.
- R4: Among eligible pending channels, the lowest channel number is offered first.
- R5: A pending channel is eligible only if its number is lower than that of every in-service channel. A request with equal or lower priority waits until the blocking handlers return.
- R6: An acknowledge while in OFFER clears the offered channel's pending bit, marks it in service and moves to FETCH. `int_ack` has no effect in any other state.
- R7: A `int_return` pulse clears the in-service bit of the lowest-numbered channel in service. This can release a waiting lower-priority request.
- R8: A vector word with bit 0 clear yields `dispatch_seg`=1 and `seg_desc` equal to the whole word.
- R9: A vector word with bit 0 set yields `dispatch_seg`=0, `entry_addr` equal to the word with bits 2:0 cleared, and `entry_prot` equal to bits 2:1.
- R10: `dispatch_valid` is high for exactly one cycle, in the cycle after `vec_valid` is seen in FETCH. The controller is then back in IDLE.
- R11: While `int_req` is high and unacknowledged, `int_req` stays high and `int_id` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Request lines, edge sensitive |
| cycle_end | input | 1 | End-of-instruction strobe from the core |
| int_enable | input | 1 | Core's interrupt-enable flag |
| int_ack | input | 1 | Core accepts the offered request |
| int_return | input | 1 | Core executed return-from-interrupt |
| vec_valid | input | 1 | Vector word on `vec_entry` is valid |
| vec_entry | input | VEC_W | Fetched vector-table word |
| int_req | output | 1 | A request is being offered |
| int_id | output | ID_W | Channel number of the offered request |
| dispatch_valid | output | 1 | Decoded dispatch fields are valid |
| dispatch_seg | output | 1 | 1: segment-descriptor dispatch, 0: direct address |
| seg_desc | output | VEC_W | Segment descriptor word |
| entry_addr | output | VEC_W | Direct handler address, 8-word aligned |
| entry_prot | output | ALIGN_BITS-1 | Protection bits of a direct entry |

## Verification
The bench builds the block with its defaults: sixteen channels, 32-bit vector words and 8-word alignment. With these values, every channel can take part in nesting up to the full depth, including cases where channel 0 preempts everything and channel 15 stays blocked behind all the others. Directed sequences cover gating at the instruction boundary, preemption, and release on return. A long randomised phase then drives overlapping edges, late acknowledges and returns that land in every state.

// File: rtl/nic_pkg.sv
package nic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_OFFER    = 2'd1,
        ST_FETCH    = 2'd2,
        ST_DISPATCH = 2'd3
    } nic_state_e;

endpackage

// File: rtl/nic_edge_capture.sv
module nic_edge_capture #(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] lines,
    input  logic [NUM_IRQ-1:0] clr_mask,
    output logic [NUM_IRQ-1:0] pending
);

    logic [NUM_IRQ-1:0] lines_q;
    logic [NUM_IRQ-1:0] rise;

    // a fresh edge wins over a clear in the same cycle
    assign rise = lines & ~lines_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= '0;
            pending <= '0;
        end else begin
            lines_q <= lines;
            pending <= (pending & ~clr_mask) | rise;
        end
    end

endmodule

// File: rtl/nic_prio_arbiter.sv
module nic_prio_arbiter #(
    parameter int NUM_IRQ = 16,
    parameter int ID_W    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] pending,
    input  logic [NUM_IRQ-1:0] in_service,
    output logic               found,
    output logic [ID_W-1:0]    win_id
);

    // blocked[i]: some channel of number <= i is in service
    logic [NUM_IRQ-1:0] blocked;
    logic [NUM_IRQ-1:0] eligible;

    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_blk
            if (g == 0) begin : g_first
                assign blocked[g] = in_service[g];
            end else begin : g_rest
                assign blocked[g] = in_service[g] | blocked[g-1];
            end
        end
    endgenerate

    assign eligible = pending & ~blocked;

    always_comb begin
        found  = 1'b0;
        win_id = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found  = 1'b1;
                win_id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/nic_vec_decode.sv
module nic_vec_decode #(
    parameter int VEC_W      = 32,
    parameter int ALIGN_BITS = 3,
    localparam int PROT_W    = ALIGN_BITS - 1
) (
    input  logic [VEC_W-1:0]  entry,
    output logic              is_seg,
    output logic [VEC_W-1:0]  desc,
    output logic [VEC_W-1:0]  addr,
    output logic [PROT_W-1:0] prot
);

    assign is_seg = ~entry[0];
    assign desc   = entry;
    assign addr   = {entry[VEC_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    assign prot   = entry[ALIGN_BITS-1:1];

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_IRQ    = 16,
    parameter int VEC_W      = 32,
    parameter int ALIGN_BITS = 3,
    localparam int ID_W      = $clog2(NUM_IRQ),
    localparam int PROT_W    = ALIGN_BITS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cycle_end,
    input  logic               int_enable,
    input  logic               int_ack,
    input  logic               int_return,
    input  logic               vec_valid,
    input  logic [VEC_W-1:0]   vec_entry,
    output logic               int_req,
    output logic [ID_W-1:0]    int_id,
    output logic               dispatch_valid,
    output logic               dispatch_seg,
    output logic [VEC_W-1:0]   seg_desc,
    output logic [VEC_W-1:0]   entry_addr,
    output logic [PROT_W-1:0]  entry_prot
);

    nic_state_e state, state_nx;

    logic [NUM_IRQ-1:0] pending;
    logic [NUM_IRQ-1:0] in_service;
    logic [NUM_IRQ-1:0] clr_mask;
    logic [NUM_IRQ-1:0] cur_onehot;
    logic [NUM_IRQ-1:0] svc_lowest;
    logic               win_found;
    logic [ID_W-1:0]    win_id;
    logic [ID_W-1:0]    cur_id;
    logic               take_ack;
    logic               take_vec;
    logic               dec_seg;
    logic [VEC_W-1:0]   dec_desc;
    logic [VEC_W-1:0]   dec_addr;
    logic [PROT_W-1:0]  dec_prot;

    nic_edge_capture #(.NUM_IRQ(NUM_IRQ)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_in),
        .clr_mask (clr_mask),
        .pending  (pending)
    );

    nic_prio_arbiter #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_arb (
        .pending    (pending),
        .in_service (in_service),
        .found      (win_found),
        .win_id     (win_id)
    );

    nic_vec_decode #(.VEC_W(VEC_W), .ALIGN_BITS(ALIGN_BITS)) u_dec (
        .entry  (vec_entry),
        .is_seg (dec_seg),
        .desc   (dec_desc),
        .addr   (dec_addr),
        .prot   (dec_prot)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cycle_end && int_enable && win_found) state_nx = ST_OFFER;
            ST_OFFER:    if (int_ack)   state_nx = ST_FETCH;
            ST_FETCH:    if (vec_valid) state_nx = ST_DISPATCH;
            ST_DISPATCH: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_req        = 1'b0;
        dispatch_valid = 1'b0;
        take_ack       = 1'b0;
        take_vec       = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_OFFER:    begin int_req = 1'b1; take_ack = int_ack; end
            ST_FETCH:    take_vec = vec_valid;
            ST_DISPATCH: dispatch_valid = 1'b1;
        endcase
    end

    assign int_id = cur_id;

    always_comb begin
        cur_onehot = '0;
        cur_onehot[cur_id] = 1'b1;
    end

    assign clr_mask   = take_ack ? cur_onehot : '0;
    assign svc_lowest = in_service & (~in_service + NUM_IRQ'(1));

    // offered channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_id <= '0;
        end else if (state == ST_IDLE && state_nx == ST_OFFER) begin
            cur_id <= win_id;
        end
    end

    // in-service mask: return clears the lowest bit, acknowledge sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_service <= '0;
        end else begin
            in_service <= (in_service & ~(int_return ? svc_lowest : '0))
                          | (take_ack ? cur_onehot : '0);
        end
    end

    // dispatch fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dispatch_seg <= 1'b0;
            seg_desc     <= '0;
            entry_addr   <= '0;
            entry_prot   <= '0;
        end else if (take_vec) begin
            dispatch_seg <= dec_seg;
            seg_desc     <= dec_desc;
            entry_addr   <= dec_addr;
            entry_prot   <= dec_prot;
        end
    end

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int NUM_IRQ = 16,
    parameter int ID_W    = 4,
    parameter int VEC_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cycle_end,
    input logic               int_enable,
    input logic               int_ack,
    input logic               int_req,
    input logic [ID_W-1:0]    int_id,
    input logic               dispatch_valid,
    input logic               dispatch_seg,
    input logic [VEC_W-1:0]   entry_addr,
    input logic [NUM_IRQ-1:0] in_service
);

    logic [NUM_IRQ-1:0] svc_at_or_above;

    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++)
            svc_at_or_above[i] = in_service[i] && (i <= int'(int_id));
    end

    AST_REQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> $past(cycle_end && int_enable)); // R3

    AST_GRANT_BEATS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_req) |-> (svc_at_or_above == '0)); // R5

    AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> in_service[$past(int_id)]); // R6

    AST_DIRECT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch_valid && !dispatch_seg) |-> (entry_addr[2:0] == 3'b000)); // R9

    AST_DISPATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |=> !dispatch_valid); // R10

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> (int_req && $stable(int_id))); // R11

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .NUM_IRQ(NUM_IRQ), .ID_W(ID_W), .VEC_W(VEC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cycle_end      (cycle_end),
    .int_enable     (int_enable),
    .int_ack        (int_ack),
    .int_req        (int_req),
    .int_id         (int_id),
    .dispatch_valid (dispatch_valid),
    .dispatch_seg   (dispatch_seg),
    .entry_addr     (entry_addr),
    .in_service     (in_service)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        cycle_end = 1'b0, int_enable = 1'b0, int_ack = 1'b0;
    logic        int_return = 1'b0, vec_valid = 1'b0;
    logic [31:0] vec_entry = '0;
    logic        int_req, dispatch_valid, dispatch_seg;
    logic [3:0]  int_id;
    logic [31:0] seg_desc, entry_addr;
    logic [1:0]  entry_prot;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cycle_end(cycle_end),
        .int_enable(int_enable), .int_ack(int_ack), .int_return(int_return),
        .vec_valid(vec_valid), .vec_entry(vec_entry), .int_req(int_req),
        .int_id(int_id), .dispatch_valid(dispatch_valid),
        .dispatch_seg(dispatch_seg), .seg_desc(seg_desc),
        .entry_addr(entry_addr), .entry_prot(entry_prot)
    );

    // ---------------- behavioural reference ----------------
    int          m_state = 0; // 0 idle, 1 offer, 2 fetch, 3 dispatch
    int          m_id = 0;
    bit [N-1:0]  m_pend = '0, m_ins = '0, m_prev = '0;
    bit          m_seg = 0;
    logic [31:0] m_desc = '0, m_addr = '0;
    logic [1:0]  m_prot = '0;

    function automatic int lowest(bit [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_id = 0; m_pend = '0; m_ins = '0; m_prev = '0;
        end else begin
            bit [N-1:0] rise, clr, nins;
            int p, s;
            rise = irq_in & ~m_prev;
            m_prev = irq_in;
            p = lowest(m_pend);
            s = lowest(m_ins);
            clr = '0;
            nins = m_ins;
            if (int_return && s < N) nins[s] = 1'b0;
            case (m_state)
                0: if (cycle_end && int_enable && p < s) begin m_state = 1; m_id = p; end
                1: if (int_ack) begin nins[m_id] = 1'b1; clr[m_id] = 1'b1; m_state = 2; end
                2: if (vec_valid) begin
                       m_seg  = !vec_entry[0];
                       m_desc = vec_entry;
                       m_addr = {vec_entry[31:3], 3'b000};
                       m_prot = vec_entry[2:1];
                       m_state = 3;
                   end
                default: m_state = 0;
            endcase
            m_pend = (m_pend & ~clr) | rise;
            m_ins = nins;
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int_req == (m_state == 1), "R3/R4/R5 int_req", int_req, m_state == 1);
            if (m_state == 1) chk(int_id == m_id[3:0], "R4/R5 int_id", int_id, m_id);
            chk(dispatch_valid == (m_state == 3), "R10 dispatch_valid", dispatch_valid, m_state == 3);
            if (m_state == 3) begin
                chk(dispatch_seg == m_seg, "R8/R9 dispatch_seg", dispatch_seg, m_seg);
                if (m_seg) chk(seg_desc == m_desc, "R8 seg_desc", seg_desc, m_desc);
                else begin
                    chk(entry_addr == m_addr, "R9 entry_addr", entry_addr, m_addr);
                    chk(entry_prot == m_prot, "R9 entry_prot", entry_prot, m_prot);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic boundary(bit ie);
        cycle_end = 1; int_enable = ie; tick(); cycle_end = 0;
    endtask

    task automatic serve(logic [31:0] vec);
        int_ack = 1; tick(); int_ack = 0;
        vec_entry = vec; vec_valid = 1; tick(); vec_valid = 0;
    endtask

    initial begin
        @(negedge clk); tick(); tick();
        // R1 reset state
        chk(int_req == 0, "R1 int_req after reset", int_req, 0);
        chk(dispatch_valid == 0, "R1 dispatch_valid after reset", dispatch_valid, 0);
        rst_n = 1; tick();
        boundary(1); tick();
        chk(int_req == 0, "R1 nothing pending after reset", int_req, 0);

        // R3: pending channel 5 gated by enable and boundary
        irq_in[5] = 1; tick(); tick();
        chk(int_req == 0, "R3 no offer without cycle_end", int_req, 0);
        boundary(0);
        chk(int_req == 0, "R3 no offer with int_enable low", int_req, 0);
        boundary(1);
        chk(int_req == 1 && int_id == 5, "R3 offer at boundary", int_id, 5);
        tick(); tick();
        chk(int_req == 1 && int_id == 5, "R11 offer held until ack", int_id, 5);
        // R9 direct entry
        serve(32'h0000_1235);
        chk(dispatch_valid == 1 && dispatch_seg == 0, "R10 dispatch after vector", dispatch_valid, 1);
        chk(entry_addr == 32'h0000_1230, "R9 aligned address", entry_addr, 32'h1230);
        chk(entry_prot == 2'b10, "R9 protection bits", entry_prot, 2);
        tick();
        chk(dispatch_valid == 0, "R10 single-cycle dispatch", dispatch_valid, 0);
        int_return = 1; tick(); int_return = 0;
        boundary(1);
        chk(int_req == 0, "R2 held level gives no second request", int_req, 0);
        irq_in[5] = 0;

        // R4: simultaneous 7 and 3
        irq_in[7] = 1; irq_in[3] = 1; tick(); tick();
        boundary(1);
        chk(int_req == 1 && int_id == 3, "R4 lowest number first", int_id, 3);
        serve(32'hABCD_0010);
        chk(dispatch_seg == 1 && seg_desc == 32'hABCD_0010, "R8 segment descriptor", seg_desc, 32'hABCD0010);
        tick();
        // R5: 7 blocked by 3 in service
        boundary(1);
        chk(int_req == 0, "R5 lower priority waits", int_req, 0);
        irq_in[1] = 1; tick(); tick();
        boundary(1);
        chk(int_req == 1 && int_id == 1, "R5 preemption by channel 1", int_id, 1);
        serve(32'h0000_0041); tick();
        // R7: return clears 1, 3 still blocks 7
        int_return = 1; tick(); int_return = 0;
        boundary(1);
        chk(int_req == 0, "R7 first return leaves 3 in service", int_req, 0);
        int_return = 1; tick(); int_return = 0;
        boundary(1);
        chk(int_req == 1 && int_id == 7, "R7 second return releases 7", int_id, 7);
        // R6: ack ignored outside OFFER
        serve(32'h0000_0081); tick();
        int_ack = 1; tick(); tick(); int_ack = 0;
        chk(int_req == 0 && dispatch_valid == 0, "R6 stray ack ignored", int_req, 0);
        int_return = 1; tick(); int_return = 0;
        irq_in = '0; tick();

        // randomised phase against the reference
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 3) == 0) irq_in[$urandom_range(0, N-1)] ^= 1'b1;
            cycle_end  = $urandom_range(0, 1);
            int_enable = ($urandom_range(0, 4) != 0);
            int_ack    = $urandom_range(0, 1);
            vec_valid  = $urandom_range(0, 1);
            vec_entry  = $urandom();
            int_return = ($urandom_range(0, 7) == 0);
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule